// File: doc/BRIEF.md
# Frame-Sync Serial ADC Reader

This block is the host side of a three-wire link to a 12-bit successive-approximation converter. It drives an active-low frame select, a serial clock made from the system clock, an active-low output enable and a line that picks the converter's input mode. It shifts in the converter's serial data and returns each result as a parallel word. The word comes with a one-cycle valid pulse and a tag that records which input mode the frame used.

A frame is sixteen serial-clock periods long and starts on the falling edge of the frame select. The serial clock falls on that same edge. The first four bit periods carry no data and are dropped. The remaining twelve bits arrive most significant bit first. They are sampled on the rising serial-clock edge, which is the edge opposite to the one on which the converter launches them.

The block has two ways to run. In single-shot mode a request starts one frame, and the select then stays high for a minimum recovery time. In continuous mode the select rises for the high half of the sixteenth period only, and falls again exactly on the sixteenth falling clock edge, so frames follow each other with no idle gap.

The controller is a three-state machine:
- IDLE: nothing is in progress.
- FRAME: sixteen clock periods are being run.
- GAP: the single-shot recovery interval.

Its transitions are:
- IDLE→FRAME when a start or a continuous request is present.
- FRAME→FRAME at the frame end when the frame is chained to the next one.
- FRAME→GAP at the frame end when it is not chained.
- GAP→IDLE after MIN_IDLE−1 cycles.

Top module: `fsadc_reader`

## Requirements
- R1: During and right after reset, `adc_cs_n_o`, `adc_sclk_o` and `adc_oe_n_o` are high and `res_valid_o` is low.
- R2: When `start_i` is sampled high in IDLE, the next cycle shows `adc_cs_n_o` and `adc_sclk_o` both falling. A single-shot frame then keeps select low for exactly 32·(DIV/2) cycles and contains 16 rising serial-clock edges.
- R3: While select is low, each serial-clock half period lasts DIV/2 system cycles. Whenever select is high, the serial clock is high.
- R4: The bits present at the rising edges of periods 5 to 16 form the result, from bit 11 down to bit 0. The values in periods 1 to 4 are discarded.
- R5: `res_valid_o` is a single-cycle pulse. It is high 31·(DIV/2) cycles after the select falling edge, in the cycle that follows the 16th rising serial-clock edge, and it carries `res_data_o` and `res_tag_o`.
- R6: `res_tag_o` equals the value `adc_chsel_o` held during the frame. A value of 0 means differential bipolar input and 1 means the second, unipolar channel.
- R7: When no frame is running, `adc_chsel_o` follows `chsel_req_i` one cycle later. It never changes while select is low, so a change of the request during a frame does not affect that frame.
- R8: While `cont_i` is high, frames run back to back. Select is high for exactly DIV/2 cycles, during the high half of the 16th period, and successive select falling edges are 32·(DIV/2) cycles apart.
- R9: `adc_oe_n_o` is low whenever select is low. In continuous operation it also stays low through the select pulses between frames. After a single-shot frame it is high while select is high.
- R10: After a single-shot frame, select stays high for at least MIN_IDLE cycles. It is exactly MIN_IDLE cycles when `start_i` is held high.
- R11: A `start_i` pulse seen during a frame or during the recovery gap is ignored and is not stored.
- R12: `cont_i` is sampled at the 16th rising edge. If it is low there, the frame ends as a single-shot frame (select low for 32·(DIV/2) cycles, then the gap), and no further frame follows.
- R13: For a chained frame, `adc_chsel_o` is loaded from `chsel_req_i` at the 16th rising edge of the frame before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-shot frame request, sampled in IDLE |
| cont_i | input | 1 | Continuous back-to-back frame enable |
| chsel_req_i | input | 1 | Requested input mode: 0 differential bipolar, 1 second channel unipolar |
| adc_cs_n_o | output | 1 | Active-low frame select to the converter |
| adc_sclk_o | output | 1 | Serial clock to the converter, idle high |
| adc_oe_n_o | output | 1 | Active-low output enable to the converter |
| adc_chsel_o | output | 1 | Input-mode select to the converter |
| adc_dout_i | input | 1 | Serial data from the converter |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_data_o | output | RES_W | Assembled conversion result |
| res_tag_o | output | 1 | Input mode the result was taken with |

## Verification
An error in the phase counter shows up within the frame where it occurs. The select low time moves away from 32·(DIV/2) cycles, the valid pulse arrives at the wrong offset, and the result word appears shifted by one or more bit positions. A wrong chain flag either drops the DIV/2-cycle select pulse or inserts one, and the change is visible at the very next frame boundary as a missing or extra frame and a wrong high time. A wrong mode latch shows up at the first valid pulse as a mismatched tag, or as `adc_chsel_o` moving while select is low.

// File: rtl/fsadc_pkg.sv
package fsadc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRAME = 2'd1,
        ST_GAP   = 2'd2
    } fsadc_state_e;

    // Serial clock periods in one conversion frame
    localparam int unsigned FSADC_FRAME_CLKS = 16;
    // Width of the conversion result
    localparam int unsigned FSADC_RES_W      = 12;

endpackage

// File: rtl/fsadc_tick.sv
// Half-period timer: pulses tick_o on the last cycle of every HALF-cycle
// interval while enabled; restarts from zero when disabled.
module fsadc_tick #(
    parameter int unsigned HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);

    generate
        if (HALF <= 1) begin : g_direct
            assign tick_o = en_i;
        end else begin : g_count
            localparam int unsigned CW = $clog2(HALF);
            logic [CW-1:0] cnt;

            assign tick_o = en_i && (cnt == CW'(HALF - 1));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (!en_i || tick_o) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/fsadc_capture.sv
// Serial-to-parallel capture, MSB first.
module fsadc_capture #(
    parameter int unsigned WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             bit_i,
    output logic [WIDTH-1:0] word_next_o
);

    logic [WIDTH-2:0] sh;

    assign word_next_o = {sh, bit_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (shift_en) begin
            sh <= word_next_o[WIDTH-2:0];
        end
    end

endmodule

// File: rtl/fsadc_reader.sv
module fsadc_reader
    import fsadc_pkg::*;
#(
    parameter int unsigned DIV        = 4,
    parameter int unsigned MIN_IDLE   = 4,
    parameter int unsigned RES_W      = FSADC_RES_W,
    parameter int unsigned FRAME_CLKS = FSADC_FRAME_CLKS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cont_i,
    input  logic             chsel_req_i,
    output logic             adc_cs_n_o,
    output logic             adc_sclk_o,
    output logic             adc_oe_n_o,
    output logic             adc_chsel_o,
    input  logic             adc_dout_i,
    output logic             res_valid_o,
    output logic [RES_W-1:0] res_data_o,
    output logic             res_tag_o
);

    localparam int unsigned HALF  = DIV / 2;
    localparam int unsigned PH_N  = 2 * FRAME_CLKS;
    localparam int unsigned PH_W  = $clog2(PH_N);
    localparam int unsigned LEAD  = FRAME_CLKS - RES_W;
    localparam int unsigned GAP_W = $clog2(MIN_IDLE);

    fsadc_state_e state, state_nx;

    logic [PH_W-1:0]  ph;        // half-period index inside the frame
    logic             chain;     // next frame follows without a gap
    logic             chsel_q;   // mode applied to the converter
    logic [GAP_W-1:0] gap_cnt;
    logic             tick;
    logic             last_ph;
    logic             rise_now;
    logic             final_rise;
    logic             frame_end;
    logic             cap_en;
    logic             gap_done;
    logic             want_frame;
    logic [RES_W-1:0] word_next;

    logic             res_valid_q;
    logic [RES_W-1:0] res_data_q;
    logic             res_tag_q;

    fsadc_tick #(.HALF(HALF)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (state == ST_FRAME),
        .tick_o (tick)
    );

    fsadc_capture #(.WIDTH(RES_W)) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .shift_en    (cap_en),
        .bit_i       (adc_dout_i),
        .word_next_o (word_next)
    );

    assign last_ph    = (ph == PH_W'(PH_N - 1));
    assign rise_now   = tick && !ph[0];
    assign final_rise = tick && (ph == PH_W'(PH_N - 2));
    assign frame_end  = tick && last_ph;
    assign cap_en     = rise_now && (ph[PH_W-1:1] >= (PH_W-1)'(LEAD));
    assign gap_done   = (gap_cnt == GAP_W'(MIN_IDLE - 2));
    assign want_frame = start_i || cont_i;

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (want_frame) state_nx = ST_FRAME;
            ST_FRAME: if (frame_end)  state_nx = chain ? ST_FRAME : ST_GAP;
            ST_GAP:   if (gap_done)   state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Frame phase, chain decision and recovery counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph      <= '0;
            chain   <= 1'b0;
            gap_cnt <= '0;
        end else begin
            if (state != ST_FRAME) begin
                ph <= '0;
            end else if (tick) begin
                ph <= last_ph ? '0 : ph + 1'b1;
            end

            if (state != ST_FRAME) begin
                chain <= 1'b0;
            end else if (final_rise) begin
                chain <= cont_i;
            end

            if (state == ST_GAP) begin
                gap_cnt <= gap_cnt + 1'b1;
            end else begin
                gap_cnt <= '0;
            end
        end
    end

    // Mode line: tracks the request between frames, frozen while selected
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chsel_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE:  if (!want_frame)           chsel_q <= chsel_req_i;
                ST_GAP:                              chsel_q <= chsel_req_i;
                ST_FRAME: if (final_rise && cont_i)  chsel_q <= chsel_req_i;
                default:                             chsel_q <= chsel_q;
            endcase
        end
    end

    // Result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid_q <= 1'b0;
            res_data_q  <= '0;
            res_tag_q   <= 1'b0;
        end else begin
            res_valid_q <= final_rise;
            if (final_rise) begin
                res_data_q <= word_next;
                res_tag_q  <= chsel_q;
            end
        end
    end

    // Link outputs
    always_comb begin
        adc_cs_n_o = 1'b1;
        adc_sclk_o = 1'b1;
        adc_oe_n_o = 1'b1;
        unique case (state)
            ST_IDLE: begin
                adc_cs_n_o = 1'b1;
            end
            ST_FRAME: begin
                adc_cs_n_o = last_ph && chain;
                adc_sclk_o = ph[0];
                adc_oe_n_o = 1'b0;
            end
            ST_GAP: begin
                adc_cs_n_o = 1'b1;
            end
            default: begin
                adc_cs_n_o = 1'b1;
            end
        endcase
    end

    assign adc_chsel_o = chsel_q;
    assign res_valid_o = res_valid_q;
    assign res_data_o  = res_data_q;
    assign res_tag_o   = res_tag_q;

endmodule

// File: rtl/fsadc_reader_chk.sv
module fsadc_reader_chk #(
    parameter int unsigned DIV = 4
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic oe_n,
    input logic chsel,
    input logic valid
);

    localparam int unsigned HALF = DIV / 2;

    logic        sclk_d;
    int unsigned run;

    // Length of the serial clock level run ending in the previous cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b1;
            run    <= 0;
        end else begin
            sclk_d <= sclk;
            if (sclk != sclk_d) begin
                run <= 1;
            end else if (run <= HALF) begin
                run <= run + 1;
            end
        end
    end

    p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);

    p_half_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$past(cs_n) && (sclk != $past(sclk))) |-> (run == HALF));

    p_start_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $fell(sclk));

    p_chsel_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> $stable(chsel));

    p_oe_in_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> !oe_n);

    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

endmodule

bind fsadc_reader fsadc_reader_chk #(.DIV(DIV)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (adc_cs_n_o),
    .sclk  (adc_sclk_o),
    .oe_n  (adc_oe_n_o),
    .chsel (adc_chsel_o),
    .valid (res_valid_o)
);

// File: tb/sim_fsadc_reader.sv
module sim_fsadc_reader;

    localparam int DIV      = 4;
    localparam int HALF     = DIV / 2;
    localparam int MIN_IDLE = 4;
    localparam int FRAME    = 32 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        cont_i = 1'b0;
    logic        chsel_req = 1'b0;
    logic        cs_n, sclk, oe_n, chsel, dout, valid, tag;
    logic [11:0] data;

    always #5 clk = ~clk;

    fsadc_reader #(.DIV(DIV), .MIN_IDLE(MIN_IDLE)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .cont_i      (cont_i),
        .chsel_req_i (chsel_req),
        .adc_cs_n_o  (cs_n),
        .adc_sclk_o  (sclk),
        .adc_oe_n_o  (oe_n),
        .adc_chsel_o (chsel),
        .adc_dout_i  (dout),
        .res_valid_o (valid),
        .res_data_o  (data),
        .res_tag_o   (tag)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Converter model and link monitor
    logic [11:0] pat_q [0:63];
    logic [11:0] cur_pat = '0;
    int fidx = 0, k = 0;
    logic prev_cs = 1'b1, prev_sclk = 1'b1, prev_chsel = 1'b0;
    int low_len = 0, high_len = 0, rises = 0;
    int last_low = 0, last_high = 0, last_rises = 0;
    int fall_cyc = 0, n_falls = 0;
    int hi_hist [0:63];
    int per_hist [0:63];
    int chsel_chg_low = 0, oe_bad_low = 0, oe_low_high = 0, sclk_bad = 0;
    logic [11:0] vdata [0:63];
    logic        vtag [0:63];
    int          vrel [0:63];
    int vcount = 0;

    initial dout = 1'b1;

    always @(negedge clk) begin
        if (valid) begin
            vdata[vcount % 64] = data;
            vtag[vcount % 64]  = tag;
            vrel[vcount % 64]  = cyc - fall_cyc;
            vcount++;
        end
        if (!cs_n && prev_cs) begin
            n_falls++;
            per_hist[n_falls % 64] = cyc - fall_cyc;
            hi_hist[n_falls % 64]  = high_len;
            last_high = high_len;
            fall_cyc = cyc;
            low_len = 1;
            rises = 0;
            k = 1;
            cur_pat = pat_q[fidx % 64];
            fidx++;
        end else if (!cs_n) begin
            low_len++;
            if (!prev_sclk && sclk) rises++;
            if (prev_sclk && !sclk) k++;
        end
        if (cs_n && !prev_cs) begin
            if (!prev_sclk && sclk) rises++;
            last_low = low_len;
            last_rises = rises;
            high_len = 1;
        end else if (cs_n) begin
            high_len++;
        end
        if (!cs_n && chsel != prev_chsel) chsel_chg_low++;
        if (!cs_n && oe_n) oe_bad_low++;
        if (cs_n && !oe_n) oe_low_high++;
        if (cs_n && !sclk) sclk_bad++;
        // leading periods carry ones so that discarding them is visible
        if (k >= 1 && k <= 4) dout = 1'b1;
        else if (k >= 5 && k <= 16) dout = cur_pat[16 - k];
        prev_cs = cs_n;
        prev_sclk = sclk;
        prev_chsel = chsel;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_valid(input int target);
        for (int i = 0; i < 4000 && vcount < target; i++) step();
    endtask

    task automatic wait_cs_high();
        for (int i = 0; i < 4000 && !cs_n; i++) step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) step();
        chk("R1", "cs_n in reset", cs_n, 1);
        chk("R1", "sclk in reset", sclk, 1);
        rst_n = 1'b1;
        repeat (3) step();
        chk("R1", "oe_n after reset", oe_n, 1);
        chk("R1", "valid after reset", valid, 0);
        chsel_req = 1'b1;
        repeat (2) step();
        chk("R7", "chsel follows request in idle", chsel, 1);
        chsel_req = 1'b0;
        repeat (2) step();
    endtask

    task automatic t_single(input logic [11:0] pat, input logic ch, input bit full);
        int b, bo;
        pat_q[fidx % 64] = pat;
        chsel_req = ch;
        repeat (2) step();
        b = vcount;
        bo = oe_low_high;
        start_i = 1'b1;
        step();
        start_i = 1'b0;
        wait_valid(b + 1);
        wait_cs_high();
        chk("R4", "result word", int'(vdata[b % 64]), int'(pat));
        chk("R6", "result tag", int'(vtag[b % 64]), int'(ch));
        if (full) begin
            chk("R5", "valid offset from select fall", vrel[b % 64], 31 * HALF);
            chk("R2", "select low length", last_low, FRAME);
            chk("R2", "rising sclk edges in frame", last_rises, 16);
            chk("R9", "oe_n low while select high", oe_low_high - bo, 0);
            chk("R9", "oe_n high while select low", oe_bad_low, 0);
            chk("R3", "sclk low while select high", sclk_bad, 0);
        end
        repeat (MIN_IDLE + 2) step();
    endtask

    task automatic t_ignore();
        int b, nf;
        pat_q[fidx % 64] = 12'h5A3;
        chsel_req = 1'b0;
        repeat (2) step();
        b = vcount;
        nf = n_falls;
        start_i = 1'b1;
        step();
        start_i = 1'b0;
        repeat (20) step();
        chsel_req = 1'b1;
        start_i = 1'b1;
        step();
        start_i = 1'b0;
        wait_valid(b + 1);
        chk("R7", "tag after mid-frame request change", int'(vtag[b % 64]), 0);
        chk("R7", "mode line moved during select low", chsel_chg_low, 0);
        wait_cs_high();
        start_i = 1'b1;
        step();
        start_i = 1'b0;
        repeat (3 * FRAME) step();
        chk("R11", "frames after ignored starts", n_falls - nf, 1);
        chk("R11", "results after ignored starts", vcount - b, 1);
        chk("R7", "mode line follows request after frame", chsel, 1);
        chsel_req = 1'b0;
        repeat (2) step();
    endtask

    task automatic t_gap();
        int b, nf;
        pat_q[fidx % 64] = 12'h001;
        pat_q[(fidx + 1) % 64] = 12'h800;
        chsel_req = 1'b1;
        repeat (2) step();
        b = vcount;
        nf = n_falls;
        start_i = 1'b1;
        for (int i = 0; i < 4000 && n_falls < nf + 2; i++) step();
        start_i = 1'b0;
        wait_valid(b + 2);
        wait_cs_high();
        chk("R10", "select high time with start held", last_high, MIN_IDLE);
        chk("R4", "first gap frame word", int'(vdata[b % 64]), 12'h001);
        chk("R4", "second gap frame word", int'(vdata[(b + 1) % 64]), 12'h800);
        chsel_req = 1'b0;
        repeat (MIN_IDLE + 2) step();
    endtask

    task automatic t_cont();
        int b, nf, bo;
        pat_q[fidx % 64] = 12'hC35;
        pat_q[(fidx + 1) % 64] = 12'h7E1;
        pat_q[(fidx + 2) % 64] = 12'h19B;
        chsel_req = 1'b0;
        repeat (2) step();
        b = vcount;
        nf = n_falls;
        bo = oe_low_high;
        cont_i = 1'b1;
        wait_valid(b + 1);
        chsel_req = 1'b1;
        wait_valid(b + 2);
        cont_i = 1'b0;
        chsel_req = 1'b0;
        wait_valid(b + 3);
        wait_cs_high();
        chk("R8", "select pulse between frames 1 and 2", hi_hist[(nf + 2) % 64], HALF);
        chk("R8", "select pulse between frames 2 and 3", hi_hist[(nf + 3) % 64], HALF);
        chk("R8", "frame period 1 to 2", per_hist[(nf + 2) % 64], FRAME);
        chk("R8", "frame period 2 to 3", per_hist[(nf + 3) % 64], FRAME);
        chk("R9", "oe_n low during select pulses", oe_low_high - bo, 2 * HALF);
        chk("R4", "continuous word 1", int'(vdata[b % 64]), 12'hC35);
        chk("R4", "continuous word 2", int'(vdata[(b + 1) % 64]), 12'h7E1);
        chk("R4", "continuous word 3", int'(vdata[(b + 2) % 64]), 12'h19B);
        chk("R13", "tag of frame 2", int'(vtag[(b + 1) % 64]), 0);
        chk("R13", "tag of frame 3", int'(vtag[(b + 2) % 64]), 1);
        chk("R12", "last frame ends as single shot", last_low, FRAME);
        repeat (3 * FRAME) step();
        chk("R12", "no frame after continuous drop", n_falls - nf, 3);
        chk("R9", "oe_n high after continuous stop", int'(oe_n), 1);
    endtask

    initial begin
        t_reset();
        t_single(12'hA5C, 1'b0, 1'b1);
        t_single(12'h3C1, 1'b1, 1'b1);
        t_single(12'hFFF, 1'b0, 1'b0);
        t_single(12'h000, 1'b1, 1'b0);
        t_single(12'h801, 1'b0, 1'b0);
        t_ignore();
        t_gap();
        t_cont();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule